// File: doc/BRIEF.md
# Serial Control Port for a Programmable-Gain Amplifier

This block is the digital control port of a programmable-gain amplifier stage. A host talks to it over a four-wire serial link with a chip select, a serial clock, a data input and a data output. Each transfer is a 16-bit word made of an 8-bit command/address byte followed by an 8-bit data byte. The port samples all four pins with the block's own system clock, so the serial clock can run at any rate well below the system clock. The system clock must run more than six times faster than the serial clock.

A single gain register sets the attenuation code that goes to the analog path, and it holds a power-down request. The power-down output is asserted when that register bit is set or when the external power-down pin is high. A word whose command bit asks for a read returns the addressed register on the data-out line during the data byte. The host can stream any number of complete words while chip select stays low. A trailing fragment shorter than a full word is dropped when chip select rises.

Top module: `amp_ctrl_spi`

## Requirements
- R1: Bits and serial-clock edges presented while chip select is high are ignored, and every chip-select assertion starts counting bits from zero.
- R2: Word format, sent MSB first: bit 15 is the read flag (1 = read, 0 = write), bits 14:8 are the register address and bits 7:0 are the data. A write takes effect on the 16th rising serial-clock edge of the word.
- R3: Several complete words sent inside one chip-select assertion are each applied in order, and a read word sees the effect of an earlier write in the same assertion.
- R4: If chip select rises after a bit count that is not a multiple of 16, the leftover bits cause no write. Complete words before them still apply.
- R5: The gain register lives at address 0x02. Bits 5:0 hold the attenuation code in dB, bit 6 holds the power-down request, and bit 7 is not stored and always reads 0.
- R6: A written attenuation value above 32 is stored and driven as 32. Values 0 to 32 are stored unchanged.
- R7: The power-down output is high exactly when the power-down register bit or the external power-down pin is high.
- R8: While powered down, register contents stay unchanged and the serial port still accepts writes and reads.
- R9: After reset, the attenuation output is 32, the power-down register bit is 0 and the gain register reads 0x20.
- R10: On a read word, the addressed register's 8 bits appear on data out MSB first during the data byte. Data out changes after falling serial-clock edges, so each bit is valid before the next rising edge.
- R11: Data out is 0 while chip select is high, during the address byte, and throughout write words.
- R12: Writes to any address other than 0x02 change nothing, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial readback data to host |
| pd_pin | input | 1 | External power-down request, active high |
| atten_code | output | 6 | Attenuation in dB applied to the gain path, 0 to 32 |
| pd_out | output | 1 | Effective power-down |

## Verification
The bench writes every possible data byte to the gain register and reads each one back within the same chip-select assertion. A design that clamped wrongly, kept bit 7, or committed the write one edge late would return the wrong byte. Truncated transfers of 15 and 21 bits are sent to catch a counter that commits partial words or fails to clear when chip select rises. Serial-clock toggles while chip select is high are sent to catch a counter that keeps counting between assertions. Reads of unused addresses, writes to unused addresses, and all four combinations of pin and register power-down check that the decode and the power-down OR leave the register untouched.

// File: rtl/amp_ctrl_pkg.sv
// Shared widths, word layout and helpers for the amplifier control port.
// Assumes a fixed 16-bit word: one read flag, 7 address bits, 8 data bits.
package amp_ctrl_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int HDR_W   = ADDR_W + 1;
    localparam int CNT_W   = $clog2(WORD_W);

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } spi_word_t;

    // Limit an attenuation request to the largest legal step count.
    function automatic logic [5:0] clamp_atten(input logic [5:0] req, input int unsigned lim);
        return (int'(req) > lim) ? 6'(lim) : req;
    endfunction
endpackage

// File: rtl/amp_pin_sync.sv
// Brings the asynchronous serial pins into the clk domain.
// Assumes clk is more than six times the serial clock rate.
// Outputs are the synchronised levels and one-cycle edge pulses for sclk.
module amp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sclk_in,
    input  logic mosi_in,
    output logic cs_n_s,
    output logic sclk_s,
    output logic mosi_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int W = 3;

    logic [W-1:0] stage [STAGES];
    logic         sclk_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Each stage delays the pin bundle by one clk.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[g] <= 3'b100;
                end else if (g == 0) begin
                    stage[g] <= {cs_n_in, sclk_in, mosi_in};
                end else begin
                    stage[g] <= stage[(g > 0) ? g-1 : 0];
                end
            end
        end
    endgenerate

    // Remembers the previous synchronised sclk for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= stage[STAGES-1][1];
    end

    assign cs_n_s    = stage[STAGES-1][2];
    assign sclk_s    = stage[STAGES-1][1];
    assign mosi_s    = stage[STAGES-1][0];
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    // An edge pulse never lasts two cycles.
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/amp_spi_frame.sv
// Assembles 16-bit words from synchronised serial pins and serialises readback.
// Assumes edge pulses from amp_pin_sync; rd_data is combinational on hdr_addr.
// The bit counter clears whenever chip select is inactive.
module amp_spi_frame
    import amp_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic              word_valid,
    output spi_word_t         word,
    output logic              miso
);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] shreg;
    logic              rd_mode;
    logic [DATA_W-1:0] tx_sh;
    logic              miso_q;
    logic              hdr_done;

    assign hdr_done   = !cs_n_s && sclk_rise && (bit_cnt == LAST_HDR);
    assign word_valid = !cs_n_s && sclk_rise && (bit_cnt == LAST_BIT);
    assign word       = {shreg, mosi_s};
    assign hdr_addr   = {shreg[ADDR_W-2:0], mosi_s};
    assign miso       = miso_q;

    // Shifts data in on rising edges and counts bits within the word.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sclk_rise) begin
            shreg   <= {shreg[WORD_W-3:0], mosi_s};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Loads readback on the header byte and shifts it out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            rd_mode <= 1'b0;
            tx_sh   <= '0;
            miso_q  <= 1'b0;
        end else begin
            if (hdr_done) begin
                rd_mode <= shreg[HDR_W-2];
                tx_sh   <= rd_data;
            end else if (word_valid) begin
                rd_mode <= 1'b0;
            end
            if (sclk_fall) begin
                miso_q <= rd_mode & tx_sh[DATA_W-1];
                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // R1
    no_word_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !word_valid);
    // R11
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !miso);
    // R10
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && $past(!cs_n_s) && !$past(sclk_fall)) |-> $stable(miso));
endmodule

// File: rtl/amp_gain_regs.sv
// Holds the gain/power-down register and decodes reads and writes.
// Assumes word_valid is a one-cycle pulse per complete word.
// Unused addresses neither store nor return data.
module amp_gain_regs
    import amp_ctrl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 7'h02,
    parameter int                ATTEN_MAX = 32,
    parameter int                ATTEN_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  spi_word_t         word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [5:0]        atten,
    output logic              pd_req
);
    logic wr_hit;

    assign wr_hit  = word_valid && !word.rd && (word.addr == GAIN_ADDR);
    assign rd_data = (rd_addr == GAIN_ADDR) ? {1'b0, pd_req, atten} : '0;

    // Stores attenuation (clamped) and the power-down request on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atten  <= 6'(ATTEN_RST);
            pd_req <= 1'b0;
        end else if (wr_hit) begin
            atten  <= clamp_atten(word.data[5:0], ATTEN_MAX);
            pd_req <= word.data[6];
        end
    end

    // R6
    atten_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(atten) <= ATTEN_MAX);
    // R12
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word.addr != GAIN_ADDR) |=> ($stable(atten) && $stable(pd_req)));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> ($stable(atten) && $stable(pd_req)));
endmodule

// File: rtl/amp_ctrl_spi.sv
// Top of the amplifier serial control port: pin sync, word assembly, registers.
// Assumes clk exceeds six times the serial clock; pd_pin is used as a level.
module amp_ctrl_spi
    import amp_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ATTEN_MAX   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic       pd_pin,
    output logic [5:0] atten_code,
    output logic       pd_out
);
    logic              cs_n_s, sclk_s, mosi_s, sclk_rise, sclk_fall;
    logic [ADDR_W-1:0] hdr_addr;
    logic [DATA_W-1:0] rd_data;
    logic              word_valid;
    spi_word_t         word;
    logic              pd_req;

    amp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_in(spi_cs_n), .sclk_in(spi_sclk), .mosi_in(spi_mosi),
        .cs_n_s(cs_n_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    amp_spi_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .rd_data(rd_data), .hdr_addr(hdr_addr),
        .word_valid(word_valid), .word(word), .miso(spi_miso)
    );

    amp_gain_regs #(.ATTEN_MAX(ATTEN_MAX), .ATTEN_RST(ATTEN_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word(word), .rd_addr(hdr_addr),
        .rd_data(rd_data), .atten(atten_code), .pd_req(pd_req)
    );

    assign pd_out = pd_req | pd_pin;

    // R7
    pin_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_pin |-> pd_out);
    // R9
    reset_atten_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (int'(atten_code) == ATTEN_MAX && !pd_req));
endmodule

// File: tb/amp_ctrl_spi_bench.sv
module amp_ctrl_spi_bench;
    localparam int HALF = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, pd_pin = 1'b0;
    logic       miso, pd_out;
    logic [5:0] atten;
    int         n_chk = 0, n_fail = 0;
    int         cyc = 0;

    always #5 clk = ~clk;

    amp_ctrl_spi u_amp_ctrl_spi (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .pd_pin(pd_pin),
        .atten_code(atten), .pd_out(pd_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Sends nbits MSB first in one chip-select period; returns data out sampled before each rise.
    task automatic xfer(input int nbits, input logic [47:0] tx, output logic [47:0] rx);
        rx = '0;
        cs_n = 1'b0;
        tick(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx = {rx[46:0], miso};
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        tick(8);
    endtask

    function automatic logic [7:0] expect_reg(input logic [7:0] d);
        logic [5:0] a;
        a = (d[5:0] > 6'd32) ? 6'd32 : d[5:0];
        return {1'b0, d[6], a};
    endfunction

    logic [47:0] rx;

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R9 reset state
        chk("R9 atten", 32'(atten), 32'd32);
        chk("R9 pd_out", 32'(pd_out), 32'd0);
        chk("R11 miso idle", 32'(miso), 32'd0);
        xfer(16, 48'h8200, rx);
        chk("R9 readback", rx[7:0], 32'h20);
        chk("R11 header byte", rx[15:8], 32'h00);

        // R2 R5 R6 R10 sweep of every data byte: write then read in one assertion
        for (int d = 0; d < 256; d++) begin
            xfer(32, {16'h0, 8'h02, 8'(d), 16'h8200}, rx);
            chk("R2 R6 atten", 32'(atten), 32'(expect_reg(8'(d)) & 8'h3F));
            chk("R5 R7 pd_out", 32'(pd_out), 32'(d[6]));
            chk("R3 R5 R10 readback", rx[7:0], 32'(expect_reg(8'(d))));
            chk("R11 write word miso", rx[31:16], 32'h0);
        end

        // R4 partial words
        xfer(16, 48'h0205, rx);
        xfer(15, 48'(16'h020A >> 1), rx);
        chk("R4 15-bit dropped", 32'(atten), 32'd5);
        xfer(21, {16'h0207, 5'b10101}, rx);
        chk("R4 word before fragment", 32'(atten), 32'd7);

        // R1 clock activity with chip select high is ignored
        for (int k = 0; k < 5; k++) begin
            mosi = k[0]; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
        end
        tick(4);
        chk("R1 idle clocks no write", 32'(atten), 32'd7);
        xfer(16, 48'h8200, rx);
        chk("R1 counter restart", rx[7:0], 32'h07);

        // R12 unused addresses
        xfer(16, 48'h0511, rx);
        chk("R12 foreign write", 32'(atten), 32'd7);
        xfer(32, 48'h85008000, rx);
        chk("R12 read 0x05", rx[23:16], 32'h0);
        chk("R12 read 0x00", rx[7:0], 32'h0);
        xfer(16, 48'h8300, rx);
        chk("R12 read 0x03", rx[7:0], 32'h0);

        // R7 all combinations of pin and register bit
        for (int c = 0; c < 4; c++) begin
            pd_pin = c[0];
            xfer(16, {32'h0, 8'h02, 1'b0, c[1], 6'd3}, rx);
            chk("R7 pd or", 32'(pd_out), 32'(c[0] | c[1]));
        end

        // R8 registers kept and port usable while powered down
        pd_pin = 1'b1;
        xfer(16, 48'h0249, rx);
        chk("R8 write while down", 32'(atten), 32'd9);
        tick(20);
        chk("R8 held while down", 32'(atten), 32'd9);
        xfer(16, 48'h8200, rx);
        chk("R8 readback while down", rx[7:0], 32'h49);
        pd_pin = 1'b0;
        tick(4);
        chk("R8 pd_out from reg", 32'(pd_out), 32'd1);
        chk("R8 atten after pin drop", 32'(atten), 32'd9);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: counts clk cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule